// File: doc/BRIEF.md
# Dual-I/O DDR serial flash read engine

This block is the host side of a double-data-rate read from a serial NOR flash over two data pins. A request carries the start address, the byte count, the opcode choice, the extended-address setting, the mode byte, the number of latency clocks, and an optional expected learning pattern. For each accepted request the engine lowers chip select and sends an 8-bit opcode one bit per clock on IO0. It then sends a 3- or 4-byte address and the mode byte at two bits per SCK edge on IO0 and IO1. Next it releases both lines for the latency clocks, optionally captures the learning pattern, and finally captures the data bytes at two bits per edge.

Bytes come out on a simple stream with a one-cycle valid pulse, and a done pulse marks the rise of chip select. When the mode byte equals a configured continuation code, the engine remembers that the device stays in continuous mode. Its next access then begins directly with the address phase. Any other mode value ends continuous mode. After each access chip select is held high for a minimum number of system clocks before the next request is accepted.

All transfers are timed in half-SCK slots of `HALF` system clocks. `HALF = ceil(SYS_MHZ / (2*SCK_MAX_MHZ))`, so SCK never exceeds `SCK_MAX_MHZ` (66 MHz by default). With the default 250 MHz system clock, `HALF` is 2.

Top module: `ddio_flash_reader`

## Requirements
- R1: After reset, flash_cs_n=1, flash_sck=0, io_oe=00, req_ready=1, rd_valid=0, rd_done=0, dlp_err=0 and cont_mode=0.
- R2: Every SCK level lasts exactly HALF system clocks, with HALF = ceil(SYS_MHZ/(2*SCK_MAX_MHZ)) (2 at 250 MHz). SCK is low during the first slot after chip select falls, and it is low whenever chip select is high.
- R3: Outside continuous mode, the opcode is sent first on io_out[0] with io_oe=01, MSB first, each bit held for one full SCK period. It changes only as SCK falls. The opcode is BDh when req_wide_op=0 and BEh when req_wide_op=1.
- R4: The address is 4 bytes (A31..A0) when req_wide_op=1 or req_ext_addr=1. Otherwise it is 3 bytes (A23..A0).
- R5: Address and then mode byte are driven with io_oe=11, two bits per half-SCK slot, MSB pair first, with io_out[1] carrying the higher bit of each pair.
- R6: Immediately after the mode byte, both lines are released (io_oe=00) for req_dummy SCK periods. A value of 0 skips this phase.
- R7: With req_dlp_en=1, the 8 pattern bits are captured from io_in over the 4 slots after latency, MSB pair first. dlp_err is set if they differ from req_dlp, and it is cleared when the next request is accepted.
- R8: Each data byte is assembled from io_in over 4 consecutive slots, MSB pair first, with io_in[1] carrying the higher bit. rd_data is presented with a one-cycle rd_valid pulse in the clock after the byte's last slot.
- R9: After exactly req_len bytes (req_len at least 1), chip select rises and rd_done pulses for one cycle in that same clock.
- R10: When an access's mode byte equals CONT_CODE (A5h by default), cont_mode becomes 1 and the next access skips the opcode phase. Any other mode byte clears cont_mode.
- R11: req_ready stays low for DESEL_CLKS system clocks after chip select rises, and then returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_ready | output | 1 | Engine idle and deselect time elapsed |
| req_addr | input | 32 | Start address |
| req_len | input | LEN_W | Number of bytes to read (at least 1) |
| req_wide_op | input | 1 | 1 selects opcode BEh, 0 selects BDh |
| req_ext_addr | input | 1 | Extended-address setting for opcode BDh |
| req_mode | input | 8 | Mode byte to send |
| req_dummy | input | DUMMY_W | Latency clocks |
| req_dlp_en | input | 1 | Capture and check a learning pattern |
| req_dlp | input | 8 | Expected learning pattern |
| flash_cs_n | output | 1 | Chip select, active low |
| flash_sck | output | 1 | Serial clock |
| io_out | output | 2 | Drive values for IO1, IO0 |
| io_oe | output | 2 | Drive enables for IO1, IO0 |
| io_in | input | 2 | Sampled values of IO1, IO0 |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | rd_data valid for one cycle |
| rd_done | output | 1 | One-cycle pulse when the access ends |
| dlp_err | output | 1 | Learning pattern mismatch on the last access |
| cont_mode | output | 1 | Device is held in continuous mode |

## Verification
The assertions assume that req_len is never zero and that a request is raised only while req_ready is high. The request fields are assumed to stay within their declared widths. The bench raises req_valid for a single cycle at an idle point and uses byte counts from 1 to 4, so every access ends cleanly. It drives io_in only with a value that is held for a full half-SCK slot and changed just after the slot begins, which matches the engine's end-of-slot sampling.

// File: rtl/ddio_flash_reader.sv
module ddio_flash_reader #(
  parameter int SYS_MHZ = 250,
  parameter int SCK_MAX_MHZ = 66,
  parameter int LEN_W = 8,
  parameter int DUMMY_W = 5,
  parameter int DESEL_CLKS = 4,
  parameter logic [7:0] CONT_CODE = 8'hA5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [31:0]        req_addr,
  input  logic [LEN_W-1:0]   req_len,
  input  logic               req_wide_op,
  input  logic               req_ext_addr,
  input  logic [7:0]         req_mode,
  input  logic [DUMMY_W-1:0] req_dummy,
  input  logic               req_dlp_en,
  input  logic [7:0]         req_dlp,
  output logic               flash_cs_n,
  output logic               flash_sck,
  output logic [1:0]         io_out,
  output logic [1:0]         io_oe,
  input  logic [1:0]         io_in,
  output logic [7:0]         rd_data,
  output logic               rd_valid,
  output logic               rd_done,
  output logic               dlp_err,
  output logic               cont_mode
);

  localparam int HALF = (SYS_MHZ + 2*SCK_MAX_MHZ - 1) / (2*SCK_MAX_MHZ);
  localparam int DVW  = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int CW   = (LEN_W + 2 > DUMMY_W + 2) ? ((LEN_W + 2 > 8) ? LEN_W + 2 : 8)
                                                   : ((DUMMY_W + 2 > 8) ? DUMMY_W + 2 : 8);

  typedef enum logic [2:0] {S_IDLE, S_OPC, S_ADDR, S_MODE, S_DUMMY, S_DLP, S_DATA, S_DESEL} st_t;

  st_t st;
  logic [DVW-1:0]     div;
  logic [CW-1:0]      cnt;
  logic               sck_r;
  logic [7:0]         opc_sh, mode_sh, mode_q, dlp_q;
  logic [31:0]        adr_sh;
  logic               a4_q, dlp_en_q;
  logic [DUMMY_W-1:0] dum_q;
  logic [LEN_W-1:0]   len_q;
  logic [5:0]         cap;

  logic    slot_end, active;
  st_t     lat_st, post_st;
  logic [CW-1:0] lat_cnt, post_cnt, data_cnt, adr_cnt;

  assign slot_end = (div == DVW'(HALF - 1));
  assign active   = (st != S_IDLE) && (st != S_DESEL);
  assign data_cnt = CW'({len_q, 2'b00}) - CW'(1);
  assign adr_cnt  = a4_q ? CW'(15) : CW'(11);

  always_comb begin
    if (dlp_en_q) begin post_st = S_DLP;  post_cnt = CW'(3);   end
    else          begin post_st = S_DATA; post_cnt = data_cnt; end
    if (dum_q != '0) begin
      lat_st  = S_DUMMY;
      lat_cnt = CW'({dum_q, 1'b0}) - CW'(1);
    end else begin
      lat_st  = post_st;
      lat_cnt = post_cnt;
    end
  end

  assign req_ready  = (st == S_IDLE);
  assign flash_cs_n = (st == S_IDLE) || (st == S_DESEL);
  assign flash_sck  = sck_r;
  assign io_out = (st == S_OPC)  ? {1'b0, opc_sh[7]} :
                  (st == S_ADDR) ? adr_sh[31:30] :
                  (st == S_MODE) ? mode_sh[7:6] : 2'b00;
  assign io_oe  = (st == S_OPC) ? 2'b01 :
                  (st == S_ADDR || st == S_MODE) ? 2'b11 : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      div <= '0;
      cnt <= '0;
      sck_r <= 1'b0;
      opc_sh <= '0;
      mode_sh <= '0;
      mode_q <= '0;
      dlp_q <= '0;
      adr_sh <= '0;
      a4_q <= 1'b0;
      dlp_en_q <= 1'b0;
      dum_q <= '0;
      len_q <= '0;
      cap <= '0;
      rd_data <= '0;
      rd_valid <= 1'b0;
      rd_done <= 1'b0;
      dlp_err <= 1'b0;
      cont_mode <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      rd_done  <= 1'b0;
      if (active) begin
        div <= slot_end ? '0 : div + 1'b1;
        if (slot_end) sck_r <= ~sck_r;
      end
      case (st)
        S_IDLE: if (req_valid) begin
          opc_sh   <= req_wide_op ? 8'hBE : 8'hBD;
          a4_q     <= req_wide_op | req_ext_addr;
          adr_sh   <= (req_wide_op | req_ext_addr) ? req_addr : {req_addr[23:0], 8'h00};
          mode_sh  <= req_mode;
          mode_q   <= req_mode;
          dum_q    <= req_dummy;
          dlp_en_q <= req_dlp_en;
          dlp_q    <= req_dlp;
          len_q    <= req_len;
          dlp_err  <= 1'b0;
          div      <= '0;
          sck_r    <= 1'b0;
          if (cont_mode) begin
            st  <= S_ADDR;
            cnt <= (req_wide_op | req_ext_addr) ? CW'(15) : CW'(11);
          end else begin
            st  <= S_OPC;
            cnt <= CW'(15);
          end
        end
        S_OPC: if (slot_end) begin
          if (cnt == '0) begin
            st  <= S_ADDR;
            cnt <= adr_cnt;
          end else begin
            cnt <= cnt - 1'b1;
            if (!cnt[0]) opc_sh <= {opc_sh[6:0], 1'b0};
          end
        end
        S_ADDR: if (slot_end) begin
          adr_sh <= {adr_sh[29:0], 2'b00};
          if (cnt == '0) begin
            st  <= S_MODE;
            cnt <= CW'(3);
          end else cnt <= cnt - 1'b1;
        end
        S_MODE: if (slot_end) begin
          mode_sh <= {mode_sh[5:0], 2'b00};
          if (cnt == '0) begin
            st  <= lat_st;
            cnt <= lat_cnt;
          end else cnt <= cnt - 1'b1;
        end
        S_DUMMY: if (slot_end) begin
          if (cnt == '0) begin
            st  <= post_st;
            cnt <= post_cnt;
          end else cnt <= cnt - 1'b1;
        end
        S_DLP: if (slot_end) begin
          cap <= {cap[3:0], io_in};
          if (cnt == '0) begin
            dlp_err <= ({cap, io_in} != dlp_q);
            st  <= S_DATA;
            cnt <= data_cnt;
          end else cnt <= cnt - 1'b1;
        end
        S_DATA: if (slot_end) begin
          cap <= {cap[3:0], io_in};
          if (cnt[1:0] == 2'b00) begin
            rd_data  <= {cap, io_in};
            rd_valid <= 1'b1;
          end
          if (cnt == '0) begin
            st        <= S_DESEL;
            cnt       <= CW'(DESEL_CLKS - 1);
            rd_done   <= 1'b1;
            cont_mode <= (mode_q == CONT_CODE);
          end else cnt <= cnt - 1'b1;
        end
        S_DESEL: begin
          if (cnt == '0) st <= S_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_sck_low_deselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flash_cs_n |-> !flash_sck);

  p_sck_held_in_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_cs_n && $past(!flash_cs_n) && div != '0) |-> $stable(flash_sck));

  p_opcode_falling_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OPC && $past(st == S_OPC) && io_out != $past(io_out)) |-> (!flash_sck && $past(flash_sck)));

  p_release_after_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MODE && slot_end && cnt == '0) |=> (io_oe == 2'b00));

  p_byte_from_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(st == S_DATA));

  p_done_with_cs_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> (flash_cs_n && !$past(flash_cs_n)));

  p_opcode_only_outside_cont_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st == S_IDLE) && st == S_OPC) |-> !cont_mode);

  p_no_ready_at_deselect_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_cs_n) |-> !req_ready);

endmodule

// File: tb/ddio_flash_reader_bench.sv
module ddio_flash_reader_bench;
  localparam int H   = 2;
  localparam int DES = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_addr = '0;
  logic [7:0]  req_len = '0;
  logic        req_wide_op = 1'b0, req_ext_addr = 1'b0;
  logic [7:0]  req_mode = '0;
  logic [4:0]  req_dummy = '0;
  logic        req_dlp_en = 1'b0;
  logic [7:0]  req_dlp = '0;
  logic        flash_cs_n, flash_sck;
  logic [1:0]  io_out, io_oe;
  logic [1:0]  io_in = 2'b00;
  logic [7:0]  rd_data;
  logic        rd_valid, rd_done, dlp_err, cont_mode;

  ddio_flash_reader u_ddio_flash_reader (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_wide_op(req_wide_op),
    .req_ext_addr(req_ext_addr), .req_mode(req_mode), .req_dummy(req_dummy),
    .req_dlp_en(req_dlp_en), .req_dlp(req_dlp), .flash_cs_n(flash_cs_n),
    .flash_sck(flash_sck), .io_out(io_out), .io_oe(io_oe), .io_in(io_in),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_done(rd_done),
    .dlp_err(dlp_err), .cont_mode(cont_mode));

  typedef struct packed {
    logic cs_n, sck;
    logic [1:0] oe, out, din;
    logic bv;
    logic [7:0] bd;
    logic dn, rdy;
  } cyc_t;

  cyc_t  exp_q[$];
  string tag_q[$];
  int    checks = 0, failures = 0;
  int    slot_k;
  logic  pend_bv;
  logic [7:0] pend_bd;
  logic  model_cont = 1'b0;

  function automatic logic [7:0] mem_byte(logic [31:0] a);
    return (a[7:0] * 8'd7) ^ 8'h5C;
  endfunction

  task automatic chk(bit ok, string tag, string what, int got, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s got=%0h exp=%0h at %0t", tag, what, got, expv, $time);
    end
  endtask

  task automatic add_slot(logic [1:0] oe, logic [1:0] out, logic [1:0] din, string tag,
                          logic bv_after, logic [7:0] bd_after);
    for (int h = 0; h < H; h++) begin
      cyc_t e;
      e.cs_n = 1'b0; e.sck = slot_k[0]; e.oe = oe; e.out = out; e.din = din;
      e.bv = (h == 0) ? pend_bv : 1'b0; e.bd = pend_bd; e.dn = 1'b0; e.rdy = 1'b0;
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
    pend_bv = bv_after;
    pend_bd = bd_after;
    slot_k++;
  endtask

  task automatic build(logic [31:0] addr, int len, logic wide, logic ext, logic [7:0] mode,
                       int dummy, logic dlp_on, logic [7:0] dlp_sent);
    logic [7:0] op;
    logic [31:0] a32;
    int nb;
    slot_k = 0; pend_bv = 1'b0; pend_bd = '0;
    op = wide ? 8'hBE : 8'hBD;
    if (!model_cont)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 2; j++) add_slot(2'b01, {1'b0, op[7-i]}, 2'b00, "R3", 1'b0, 8'h00);
    nb  = (wide || ext) ? 4 : 3;
    a32 = (nb == 4) ? addr : {addr[23:0], 8'h00};
    for (int s = 0; s < 4*nb; s++) add_slot(2'b11, a32[31-2*s -: 2], 2'b00, "R4", 1'b0, 8'h00);
    for (int s = 0; s < 4; s++) add_slot(2'b11, mode[7-2*s -: 2], 2'b00, "R5", 1'b0, 8'h00);
    for (int s = 0; s < 2*dummy; s++) add_slot(2'b00, 2'b00, 2'b00, "R6", 1'b0, 8'h00);
    if (dlp_on)
      for (int s = 0; s < 4; s++) add_slot(2'b00, 2'b00, dlp_sent[7-2*s -: 2], "R7", 1'b0, 8'h00);
    for (int b = 0; b < len; b++) begin
      logic [7:0] d;
      d = mem_byte(addr + b);
      for (int s = 0; s < 4; s++) add_slot(2'b00, 2'b00, d[7-2*s -: 2], "R8", s == 3, d);
    end
    for (int c = 0; c <= DES; c++) begin
      cyc_t e;
      e.cs_n = 1'b1; e.sck = 1'b0; e.oe = 2'b00; e.out = 2'b00; e.din = 2'b00;
      e.bv = (c == 0) ? pend_bv : 1'b0; e.bd = pend_bd; e.dn = (c == 0);
      e.rdy = (c == DES);
      exp_q.push_back(e);
      tag_q.push_back((c == 0) ? "R9" : "R11");
    end
    model_cont = (mode == 8'hA5);
  endtask

  task automatic run_req(logic [31:0] addr, int len, logic wide, logic ext, logic [7:0] mode,
                         int dummy, logic dlp_on, logic [7:0] dlp_exp, logic [7:0] dlp_sent);
    bit first;
    @(negedge clk);
    req_addr = addr; req_len = 8'(len); req_wide_op = wide; req_ext_addr = ext;
    req_mode = mode; req_dummy = 5'(dummy); req_dlp_en = dlp_on; req_dlp = dlp_exp;
    req_valid = 1'b1;
    build(addr, len, wide, ext, mode, dummy, dlp_on, dlp_sent);
    first = 1'b1;
    while (exp_q.size() > 0) begin
      cyc_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      @(negedge clk);
      if (first) req_valid = 1'b0;
      first = 1'b0;
      io_in = e.din;
      chk(flash_cs_n == e.cs_n, t, "cs_n", flash_cs_n, e.cs_n);
      chk(flash_sck == e.sck, "R2", "sck", flash_sck, e.sck);
      chk(io_oe == e.oe, t, "io_oe", io_oe, e.oe);
      chk((io_out & e.oe) == (e.out & e.oe), t, "io_out", io_out & e.oe, e.out & e.oe);
      chk(rd_valid == e.bv, "R8", "rd_valid", rd_valid, e.bv);
      if (e.bv) chk(rd_data == e.bd, "R8", "rd_data", rd_data, e.bd);
      chk(rd_done == e.dn, "R9", "rd_done", rd_done, e.dn);
      chk(req_ready == e.rdy, "R11", "req_ready", req_ready, e.rdy);
    end
    chk(dlp_err == (dlp_on && dlp_exp != dlp_sent), "R7", "dlp_err", dlp_err,
        dlp_on && dlp_exp != dlp_sent);
    chk(cont_mode == model_cont, "R10", "cont_mode", cont_mode, model_cont);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(flash_cs_n == 1'b1 && flash_sck == 1'b0 && io_oe == 2'b00, "R1", "pins", {flash_cs_n, flash_sck, io_oe}, 4'b1000);
    chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
    chk(rd_valid == 1'b0 && rd_done == 1'b0, "R1", "strobes", {rd_valid, rd_done}, 0);
    chk(dlp_err == 1'b0 && cont_mode == 1'b0, "R1", "flags", {dlp_err, cont_mode}, 0);
    rst_n = 1'b1;
    // R4: BDh, 3-byte address
    run_req(32'h0012_3456, 3, 1'b0, 1'b0, 8'h00, 4, 1'b0, 8'h00, 8'h00);
    // R4: BDh with extended address, matching pattern, enter continuous (R10)
    run_req(32'h89AB_CDEF, 2, 1'b0, 1'b1, 8'hA5, 2, 1'b1, 8'h34, 8'h34);
    // R10: no opcode, R7 mismatch, R6 zero latency
    run_req(32'h0102_0304, 4, 1'b1, 1'b0, 8'hA5, 0, 1'b1, 8'h34, 8'h35);
    // R10: leave continuous; R7 flag cleared on acceptance
    run_req(32'h00FF_0011, 1, 1'b0, 1'b0, 8'h00, 1, 1'b0, 8'h00, 8'h00);
    // R3: BEh opcode without extended setting still uses 4 address bytes
    run_req(32'hFEDC_BA98, 2, 1'b1, 1'b0, 8'h5A, 3, 1'b1, 8'hC3, 8'hC3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule